// File: doc/BRIEF.md
# Asynchronous Serial Adapter Register and Interrupt Unit

This block is the processor-side register front end of a classic two-address serial adapter. A single register-select line picks between two locations. At the first location, writes load the control word and reads return the status byte. At the second location, writes fill the transmit holding register and reads drain the receive holding register. Separate serial transmitter and receiver cores connect through plain valid/ready style signals. This unit holds their bytes, keeps every status flag and applies the access-driven rules that clear each flag.

The control word sets the character format and divide ratio that go out to the serial cores. It also sets the receive interrupt enable and the transmit control field. A divide field of 11 is a software master reset, and the unit stays in that reset until software writes some other control value. The active-low interrupt output is the inverse of the status interrupt bit. It follows the flags in the same cycle that they change.

Top module: `acia_regs`

## Requirements
- R1: With `reg_sel`=0 a write strobe loads the control word and the read data shows status. With `reg_sel`=1 a write loads the transmit holding register and the read data shows the received byte.
- R2: Synchronous `rst`, or a control write whose bits 1:0 are 11, enters master reset. Master reset clears RDRF, overrun, parity error, framing error and the DCD latch, and it empties the transmit holding register. Incoming bytes are discarded and `tx_valid` stays low while bits 1:0 of the held control word remain 11. After `rst` the control word is 0x03.
- R3: The status byte, from bit 7 down to bit 0, is IRQ, parity error, overrun, framing error, CTS, DCD, TDRE, RDRF.
- R4: An `rx_valid` pulse with RDRF=0 stores `rx_byte` and sets RDRF (bit 0) after that edge. A receive-data read clears RDRF. If a byte arrives in the same cycle as the read, the new byte is stored and RDRF stays 1.
- R5: A byte that arrives while RDRF=1 and no read happens in that cycle sets overrun (bit 5) and is dropped, and the held byte is kept. A receive-data read clears overrun.
- R6: Parity error (bit 6) and framing error (bit 4) take `rx_perr`/`rx_ferr` when a byte is stored and clear on a receive-data read.
- R7: A low-to-high change on `dcd_in` sets the DCD latch (bit 2). The latch clears only when a status read (read strobe with `reg_sel`=0) comes before a receive-data read. A receive-data read with no earlier status read leaves it set.
- R8: Bit 3 mirrors `cts_in`. While `cts_in`=1, TDRE (bit 1) reads 0.
- R9: A transmit-data write stores the byte on `tx_data`, raises `tx_valid` and makes TDRE 0. `tx_valid` and `tx_data` hold until a cycle with `tx_ready`=1, after which TDRE returns to 1.
- R10: IRQ (bit 7) = (control bit 7 AND (RDRF OR overrun OR DCD)) OR (control bits 6:5 = 01 AND TDRE). `irq_n` is its inverse, so it releases once a receive read or transmit write removes the cause.
- R11: `word_sel` carries control bits 4:2 and `div_sel` carries control bits 1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | 0: control/status, 1: transmit/receive data |
| rd_stb | input | 1 | Read strobe; side effects at the clock edge |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected location |
| irq_n | output | 1 | Active-low level interrupt |
| cts_in | input | 1 | Clear-to-send, high = not ready |
| dcd_in | input | 1 | Carrier detect input |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_valid | output | 1 | Transmit holding register full |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_byte | input | 8 | Byte from the receiver |
| rx_valid | input | 1 | One-cycle byte delivery pulse |
| rx_perr | input | 1 | Parity error of delivered byte |
| rx_ferr | input | 1 | Framing error of delivered byte |
| word_sel | output | 3 | Character format to serial cores |
| div_sel | output | 2 | Divide ratio to serial cores |

## Verification
Every flag is registered once. The effect of a strobe or a receiver pulse shows on `rd_data` and `irq_n` just after the edge that samples it, and `cts_in` shows in the same cycle. The bench changes inputs on the falling edge and samples on the next falling edge, which is one rising edge later. Read values are taken combinationally before the edge that applies the read's side effects. The two-step DCD clear, overrun and the read-versus-arrival collision each get a directed sequence that checks the state after every step.

// File: rtl/acia_pkg.sv
package acia_pkg;

    localparam int DW = 8;
    localparam logic [DW-1:0] CTRL_RST  = 8'h03;
    localparam logic [1:0]    DIV_MRST  = 2'b11;
    localparam logic [1:0]    TXC_IRQ   = 2'b01;

    typedef struct packed {
        logic       rx_ie;
        logic [1:0] tx_ctl;
        logic [2:0] word;
        logic [1:0] div;
    } ctrl_t;

    typedef struct packed {
        logic irq;
        logic perr;
        logic ovrn;
        logic ferr;
        logic cts;
        logic dcd;
        logic tdre;
        logic rdrf;
    } stat_t;

    typedef struct packed {
        logic ctrl_wr;
        logic txd_wr;
        logic stat_rd;
        logic rxd_rd;
    } acc_t;

    function automatic acc_t decode(input logic rs, input logic rd, input logic wr);
        acc_t a;
        a.ctrl_wr = wr & ~rs;
        a.txd_wr  = wr &  rs;
        a.stat_rd = rd & ~rs;
        a.rxd_rd  = rd &  rs;
        return a;
    endfunction

    function automatic logic is_mrst(input logic [1:0] div);
        return div == DIV_MRST;
    endfunction

endpackage

// File: rtl/acia_ctrl_reg.sv
module acia_ctrl_reg
    import acia_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl,
    output logic          clr
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)     ctrl_q <= ctrl_t'(CTRL_RST);
        else if (wr) ctrl_q <= ctrl_t'(wdata);
    end

    assign ctrl = ctrl_q;
    // clear is active while held in master reset and on the edge that enters it
    assign clr  = is_mrst(ctrl_q.div) | (wr & is_mrst(wdata[1:0]));
endmodule

// File: rtl/acia_tx_hold.sv
module acia_tx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] wdata,
    input  logic         tx_ready,
    output logic [W-1:0] tx_data,
    output logic         tx_valid,
    output logic         empty
);
    logic         empty_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b1;
            hold_q  <= '0;
        end else if (clr) begin
            empty_q <= 1'b1;
        end else begin
            if (!empty_q && tx_ready) empty_q <= 1'b1;
            if (load) begin
                hold_q  <= wdata;
                empty_q <= 1'b0;
            end
        end
    end

    assign tx_data  = hold_q;
    assign tx_valid = ~empty_q;
    assign empty    = empty_q;
endmodule

// File: rtl/acia_rx_hold.sv
module acia_rx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         take,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_byte,
    input  logic         rx_perr,
    input  logic         rx_ferr,
    output logic [W-1:0] data,
    output logic         full,
    output logic         ovrn,
    output logic         perr,
    output logic         ferr
);
    logic [W-1:0] data_q;
    logic         full_q, ovrn_q, perr_q, ferr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            full_q <= 1'b0;
            ovrn_q <= 1'b0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            if (rst) data_q <= '0;
        end else begin
            if (take) begin
                full_q <= 1'b0;
                ovrn_q <= 1'b0;
                perr_q <= 1'b0;
                ferr_q <= 1'b0;
            end
            if (rx_valid) begin
                if (full_q && !take) begin
                    ovrn_q <= 1'b1;
                end else begin
                    data_q <= rx_byte;
                    full_q <= 1'b1;
                    perr_q <= rx_perr;
                    ferr_q <= rx_ferr;
                end
            end
        end
    end

    assign data = data_q;
    assign full = full_q;
    assign ovrn = ovrn_q;
    assign perr = perr_q;
    assign ferr = ferr_q;
endmodule

// File: rtl/acia_dcd_latch.sv
module acia_dcd_latch (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic dcd_in,
    input  logic stat_rd,
    input  logic data_rd,
    output logic flag
);
    logic prev_q, flag_q, armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= dcd_in;
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            prev_q <= dcd_in;
            if (clr) begin
                flag_q  <= 1'b0;
                armed_q <= 1'b0;
            end else begin
                if (stat_rd && flag_q) armed_q <= 1'b1;
                if (data_rd && armed_q) begin
                    flag_q  <= 1'b0;
                    armed_q <= 1'b0;
                end
                if (dcd_in && !prev_q) begin
                    flag_q  <= 1'b1;
                    armed_q <= 1'b0;
                end
            end
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/acia_regs.sv
module acia_regs
    import acia_pkg::*;
#(
    parameter int DATA_W = DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n,
    input  logic              cts_in,
    input  logic              dcd_in,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    output logic [2:0]        word_sel,
    output logic [1:0]        div_sel
);
    acc_t  acc;
    ctrl_t ctrl;
    stat_t stat;
    logic  clr, tx_empty, rx_full, rx_ovrn, rx_perr_q, rx_ferr_q, dcd_flag;
    logic [DATA_W-1:0] rx_data;

    assign acc = decode(reg_sel, rd_stb, wr_stb);

    acia_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .wr(acc.ctrl_wr), .wdata(wr_data),
        .ctrl(ctrl), .clr(clr)
    );

    acia_tx_hold #(.W(DATA_W)) u_tx (
        .clk(clk), .rst(rst), .clr(clr), .load(acc.txd_wr), .wdata(wr_data),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
        .empty(tx_empty)
    );

    acia_rx_hold #(.W(DATA_W)) u_rx (
        .clk(clk), .rst(rst), .clr(clr), .take(acc.rxd_rd),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .data(rx_data), .full(rx_full), .ovrn(rx_ovrn),
        .perr(rx_perr_q), .ferr(rx_ferr_q)
    );

    acia_dcd_latch u_dcd (
        .clk(clk), .rst(rst), .clr(clr), .dcd_in(dcd_in),
        .stat_rd(acc.stat_rd), .data_rd(acc.rxd_rd), .flag(dcd_flag)
    );

    always_comb begin
        stat.rdrf = rx_full;
        stat.tdre = tx_empty & ~cts_in;
        stat.dcd  = dcd_flag;
        stat.cts  = cts_in;
        stat.ferr = rx_ferr_q;
        stat.ovrn = rx_ovrn;
        stat.perr = rx_perr_q;
        stat.irq  = (ctrl.rx_ie & (rx_full | rx_ovrn | dcd_flag))
                  | ((ctrl.tx_ctl == TXC_IRQ) & stat.tdre);
    end

    assign rd_data  = reg_sel ? rx_data : DATA_W'(stat);
    assign irq_n    = ~stat.irq;
    assign word_sel = ctrl.word;
    assign div_sel  = ctrl.div;
endmodule

// File: rtl/acia_regs_chk.sv
module acia_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_sel,
    input logic       rd_stb,
    input logic       wr_stb,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       irq_n,
    input logic [7:0] stat,
    input logic       rx_valid,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data
);
    // R10: status bit 7 and the pin agree
    a_r10_irq_pin: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |-> (rd_data[7] == !irq_n));

    // R4: a receive read with no new byte leaves RDRF low
    a_r4_rdrf_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && reg_sel && !rx_valid) |=> !stat[0]);

    // R5: a byte arriving into a full register raises overrun
    a_r5_ovrn_set: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && stat[0] && !(rd_stb && reg_sel) && !(wr_stb && !reg_sel))
        |=> stat[5]);

    // R7: the DCD latch survives any cycle without a receive read or control write
    a_r7_dcd_hold: assert property (@(posedge clk) disable iff (rst)
        (stat[2] && !(rd_stb && reg_sel) && !(wr_stb && !reg_sel)) |=> stat[2]);

    // R2: entering master reset clears the flags and the transmit offer
    a_r2_mreset: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !reg_sel && wr_data[1:0] == 2'b11)
        |=> (!stat[0] && !stat[5] && !stat[2] && !stat[6] && !stat[4] && !tx_valid));

    // R9: an unaccepted offer holds still
    a_r9_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !wr_stb) |=> (tx_valid && $stable(tx_data)));
endmodule

bind acia_regs acia_regs_chk u_chk (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n), .stat(stat),
    .rx_valid(rx_valid), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data)
);

// File: tb/tb_acia_regs.sv
module tb_acia_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_n;
    logic       cts_in = 1'b0, dcd_in = 1'b0;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
    logic [2:0] word_sel;
    logic [1:0] div_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    acia_regs dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n), .cts_in(cts_in),
        .dcd_in(dcd_in), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .word_sel(word_sel),
        .div_sel(div_sel)
    );

    // row: ctrl[31:24] deliver[23] pe[22] fe[21] cts[20] byte[15:8] expected status[7:0]
    localparam logic [31:0] VEC [8] = '{
        {8'h00, 4'b0000, 4'h0, 8'h00, 8'h02},
        {8'h20, 4'b0000, 4'h0, 8'h00, 8'h82},
        {8'h20, 4'b0001, 4'h0, 8'h00, 8'h08},
        {8'h80, 4'b1000, 4'h0, 8'h5A, 8'h83},
        {8'h00, 4'b1100, 4'h0, 8'h3F, 8'h43},
        {8'h80, 4'b1011, 4'h0, 8'hC3, 8'h99},
        {8'h15, 4'b0000, 4'h0, 8'h00, 8'h02},
        {8'h40, 4'b0000, 4'h0, 8'h00, 8'h02}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic ctrl_wr(input logic [7:0] v);
        reg_sel = 1'b0; wr_stb = 1'b1; wr_data = v;
        tick();
        wr_stb = 1'b0;
    endtask

    task automatic tx_wr(input logic [7:0] v);
        reg_sel = 1'b1; wr_stb = 1'b1; wr_data = v;
        tick();
        wr_stb = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic stat_rd();
        reg_sel = 1'b0; rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
    endtask

    task automatic rx_rd(output logic [7:0] d);
        reg_sel = 1'b1; rd_stb = 1'b1;
        #1 d = rd_data;
        tick();
        rd_stb = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b, input logic pe, input logic fe);
        rx_valid = 1'b1; rx_byte = b; rx_perr = pe; rx_ferr = fe;
        tick();
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
    endtask

    function automatic logic [7:0] peek();
        return rd_data;
    endfunction

    task automatic see_stat(input string req, input logic [7:0] exp);
        reg_sel = 1'b0;
        #1;
        check(req, peek(), exp);
        check({req, " irq_n"}, {7'd0, irq_n}, {7'd0, ~exp[7]});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        // R2 R3: reset state
        see_stat("R2 reset status", 8'h02);
        check("R11 reset div_sel", {6'd0, div_sel}, 8'h03);
        check("R9 reset tx_valid", {7'd0, tx_valid}, 8'h00);
        // R2: discard while held in master reset
        rx_push(8'h55, 1'b1, 1'b1);
        see_stat("R2 rx discarded in reset", 8'h02);
        tx_wr(8'hAA);
        check("R2 tx blocked in reset", {7'd0, tx_valid}, 8'h00);

        // R1 R3 R4 R6 R8 R10 R11: vector table
        foreach (VEC[i]) begin
            ctrl_wr(8'h03);
            ctrl_wr(VEC[i][31:24]);
            cts_in = VEC[i][20];
            if (VEC[i][23]) rx_push(VEC[i][15:8], VEC[i][22], VEC[i][21]);
            else tick();
            see_stat($sformatf("R3 R10 row %0d status", i), VEC[i][7:0]);
            check($sformatf("R11 row %0d word_sel", i), {5'd0, word_sel}, {5'd0, VEC[i][28:26]});
            check($sformatf("R11 row %0d div_sel", i), {6'd0, div_sel}, {6'd0, VEC[i][25:24]});
            cts_in = 1'b0;
            if (VEC[i][23]) begin
                rx_rd(d);
                check($sformatf("R1 R4 row %0d rx data", i), d, VEC[i][15:8]);
                see_stat($sformatf("R6 row %0d cleared", i), 8'h02);
            end
        end

        // R5: overrun
        ctrl_wr(8'h03); ctrl_wr(8'h00);
        rx_push(8'hA1, 1'b0, 1'b0);
        rx_push(8'hB2, 1'b0, 1'b0);
        see_stat("R5 overrun set", 8'h23);
        rx_rd(d);
        check("R5 first byte kept", d, 8'hA1);
        see_stat("R5 overrun cleared", 8'h02);

        // R4: read and arrival in the same cycle
        rx_push(8'h11, 1'b0, 1'b0);
        reg_sel = 1'b1; rd_stb = 1'b1; rx_valid = 1'b1; rx_byte = 8'h22;
        #1 d = rd_data;
        tick();
        rd_stb = 1'b0; rx_valid = 1'b0; reg_sel = 1'b0;
        check("R4 collision read old", d, 8'h11);
        see_stat("R4 collision no overrun", 8'h03);
        rx_rd(d);
        check("R4 collision new byte", d, 8'h22);

        // R7: DCD latch and two-step clear
        ctrl_wr(8'h03); ctrl_wr(8'h80);
        dcd_in = 1'b1;
        tick();
        see_stat("R7 dcd latched", 8'h86);
        rx_rd(d);
        see_stat("R7 rx read alone keeps dcd", 8'h86);
        stat_rd();
        rx_rd(d);
        see_stat("R7 status then rx clears dcd", 8'h02);
        tick();
        see_stat("R7 level held no new edge", 8'h02);
        dcd_in = 1'b0; tick();
        dcd_in = 1'b1; tick();
        see_stat("R7 second edge", 8'h86);
        ctrl_wr(8'h03);
        see_stat("R2 master reset clears dcd", 8'h02);
        dcd_in = 1'b0;

        // R9 R10: transmit path
        ctrl_wr(8'h20);
        see_stat("R10 tx irq", 8'h82);
        tx_wr(8'h3C);
        see_stat("R9 R10 tdre low after write", 8'h00);
        check("R9 tx_valid", {7'd0, tx_valid}, 8'h01);
        check("R9 tx_data", tx_data, 8'h3C);
        tick(); tick(); tick();
        check("R9 offer held", {7'd0, tx_valid}, 8'h01);
        check("R9 data held", tx_data, 8'h3C);
        tx_ready = 1'b1; tick(); tx_ready = 1'b0;
        see_stat("R9 tdre back", 8'h82);
        check("R9 tx_valid dropped", {7'd0, tx_valid}, 8'h00);
        cts_in = 1'b1;
        #1 see_stat("R8 cts masks tdre", 8'h08);
        cts_in = 1'b0;

        tick();
        finish_run();
    end
endmodule